// File: doc/BRIEF.md
# In-Band Loopback Code Detector

This block watches a received serial line, one bit per cycle that has the bit enable high. It looks for two repeating in-band loopback codes:

- an activation code: a period of five bits, four zeros then a one;
- a release code: a period of three bits, two zeros then a one.

Each code must continue without a break for a programmable number of bit periods before the block reports it. The default window is 74112 bit periods, which is 48 ms at 1.544 Mb/s.

While a code holds, the matching status output stays high. It drops as soon as the code breaks. When either status rises, a sticky interrupt request is latched if the mask input is 1. The request is cleared by a one-cycle acknowledge.

Frame alignment, transmit insertion and the loopback action itself belong to neighbouring logic.

Top module: `loopcode_detector`

## Requirements
- R1: A bit is activation-conforming when it equals the bit received five enabled bits earlier and exactly one 1 is among the five bits before it. `act_det` is high exactly when the most recent HOLD_BITS enabled bits were all activation-conforming. Starting from reset with the code 00001 repeated, `act_det` is high after 5+HOLD_BITS bits and low after 4+HOLD_BITS bits.
- R2: The release code (001 repeated) is detected on `rel_det` by the same rule, with a period of three. It is high after 3+HOLD_BITS bits from reset and low after 2+HOLD_BITS bits.
- R3: A non-conforming bit clears that code's status in the cycle after that bit. It also restarts the code's count from zero.
- R4: The status stays high for as long as the code continues, however long that is.
- R5: A cycle with `bit_en` low changes no count, no history and no status, whatever `rx_bit` does.
- R6: When `irq_mask` is 1, a rising edge of either status sets `irq` one cycle later.
- R7: When `irq_mask` is 0 at the rising edge, no request is raised. Setting the mask to 1 later, while the same detection continues, raises nothing.
- R8: `irq` stays high until `irq_ack` is pulsed, whether or not the status stays high. It is low the cycle after the acknowledge.
- R9: A low `rst_n` at a clock edge clears history, counts, both status outputs and `irq`.
- R10: Other periodic streams are never detected by either code: all zeros, alternating 01, and 0001 repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Marks a cycle that carries a line bit |
| rx_bit | input | 1 | Received line bit |
| irq_mask | input | 1 | 1 lets a new detection raise the request |
| irq_ack | input | 1 | One-cycle pulse that clears the request |
| act_det | output | 1 | Activation code present for the full window |
| rel_det | output | 1 | Release code present for the full window |
| irq | output | 1 | Sticky interrupt request |

## Verification
The bench runs each code from reset for one bit fewer than the window and for exactly the window. A count that is off by one flips one of the two results. It feeds the other periodic patterns to catch a checker that only compares the bit one period back, since such a checker would also accept an all-zero line. It breaks a held code to show that the status drops at once while `irq` stays until acknowledged. It also toggles `rx_bit` with the enable low, and clears the mask at the rising edge to catch a request raised from the level rather than the edge.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
   localparam int NUM_CODES = 2;
   localparam int MAX_PERIOD = 5;

   // index 0: activation code, index 1: release code
   function automatic int code_period(input int idx);
      return (idx == 0) ? 5 : 3;
   endfunction
endpackage

// File: rtl/lcd_history.sv
module lcd_history #(
   parameter int DEPTH = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   input  logic             rx_bit,
   output logic [DEPTH-1:0] hist
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("lcd_history: DEPTH must be at least 2");
   end

   // hist[k] is the bit received k+1 enables ago
   always_ff @(posedge clk) begin
      if (!rst_n)      hist <= '0;
      else if (bit_en) hist <= {hist[DEPTH-2:0], rx_bit};
   end

   // R5
   hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(hist));
endmodule

// File: rtl/lcd_code_match.sv
module lcd_code_match #(
   parameter int PERIOD    = 5,
   parameter int HOLD_BITS = 74112,
   localparam int CNT_W    = $clog2(HOLD_BITS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              rx_bit,
   input  logic [PERIOD-1:0] prev_bits,
   output logic              det
);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD_BITS);

   if (PERIOD < 2) begin : g_bad_period
      $error("lcd_code_match: PERIOD must be at least 2");
   end
   if (HOLD_BITS < 1) begin : g_bad_hold
      $error("lcd_code_match: HOLD_BITS must be at least 1");
   end

   logic             conform;
   logic [CNT_W-1:0] run_cnt;

   assign conform = (rx_bit == prev_bits[PERIOD-1]) &&
                    ($countones(prev_bits) == 1);

   always_ff @(posedge clk) begin
      if (!rst_n)            run_cnt <= '0;
      else if (bit_en) begin
         if (!conform)             run_cnt <= '0;
         else if (run_cnt != LIMIT) run_cnt <= run_cnt + 1'b1;
      end
   end

   assign det = (run_cnt == LIMIT);

   // R3
   break_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en && !conform |=> !det);
   // R4
   hold_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      det && bit_en && conform |=> det);
   // R5
   idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(run_cnt));
endmodule

// File: rtl/lcd_irq.sv
module lcd_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic stat_any,
   input  logic mask,
   input  logic ack,
   output logic irq
);
   logic stat_q;
   logic rise;

   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= 1'b0;
      else        stat_q <= stat_any;
   end

   assign rise = stat_any && !stat_q;

   // a new rise wins over an acknowledge in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n)           irq <= 1'b0;
      else if (rise && mask) irq <= 1'b1;
      else if (ack)          irq <= 1'b0;
   end

   // R6
   rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise && mask |=> irq);
   // R7
   masked_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq && !(rise && mask) |=> !irq);
   // R8
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !ack |=> irq);
   // R8
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack && !(rise && mask) |=> !irq);
endmodule

// File: rtl/loopcode_detector.sv
module loopcode_detector #(
   parameter int HOLD_BITS = 74112
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic rx_bit,
   input  logic irq_mask,
   input  logic irq_ack,
   output logic act_det,
   output logic rel_det,
   output logic irq
);
   import lcd_pkg::*;

   logic [MAX_PERIOD-1:0] hist;
   logic [NUM_CODES-1:0]  det_vec;

   lcd_history #(.DEPTH(MAX_PERIOD)) u_hist (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_en (bit_en),
      .rx_bit (rx_bit),
      .hist   (hist)
   );

   for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
      localparam int P = code_period(g);
      lcd_code_match #(.PERIOD(P), .HOLD_BITS(HOLD_BITS)) u_match (
         .clk       (clk),
         .rst_n     (rst_n),
         .bit_en    (bit_en),
         .rx_bit    (rx_bit),
         .prev_bits (hist[P-1:0]),
         .det       (det_vec[g])
      );
   end

   lcd_irq u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .stat_any (|det_vec),
      .mask     (irq_mask),
      .ack      (irq_ack),
      .irq      (irq)
   );

   assign act_det = det_vec[0];
   assign rel_det = det_vec[1];

   // R9
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> !act_det && !rel_det && !irq);
endmodule

// File: tb/sim_loopcode_detector.sv
module sim_loopcode_detector;
   localparam int HOLD = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_en = 1'b0;
   logic rx_bit = 1'b0;
   logic irq_mask = 1'b0;
   logic irq_ack = 1'b0;
   logic act_det, rel_det, irq;

   int n_chk = 0;
   int n_fail = 0;
   int pos = 0;

   always #10 clk = ~clk;

   loopcode_detector #(.HOLD_BITS(HOLD)) u0 (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
      .irq_mask(irq_mask), .irq_ack(irq_ack),
      .act_det(act_det), .rel_det(rel_det), .irq(irq)
   );

   // kind: 0 activation, 1 release, 2 alternating, 3 zeros, 4 period four
   typedef struct packed {
      logic [2:0] kind;
      logic [7:0] nbits;
      logic       mask;
      logic       e_act;
      logic       e_rel;
      logic       e_irq;
   } vec_t;

   localparam vec_t VECS [10] = '{
      '{3'd0, 8'd25, 1'b1, 1'b1, 1'b0, 1'b1},   // R1 exact window
      '{3'd0, 8'd24, 1'b1, 1'b0, 1'b0, 1'b0},   // R1 one short
      '{3'd1, 8'd23, 1'b1, 1'b0, 1'b1, 1'b1},   // R2 exact window
      '{3'd1, 8'd22, 1'b1, 1'b0, 1'b0, 1'b0},   // R2 one short
      '{3'd0, 8'd40, 1'b0, 1'b1, 1'b0, 1'b0},   // R7 masked
      '{3'd1, 8'd30, 1'b0, 1'b0, 1'b1, 1'b0},   // R7 masked
      '{3'd2, 8'd40, 1'b1, 1'b0, 1'b0, 1'b0},   // R10
      '{3'd3, 8'd40, 1'b1, 1'b0, 1'b0, 1'b0},   // R10
      '{3'd4, 8'd40, 1'b1, 1'b0, 1'b0, 1'b0},   // R10
      '{3'd0, 8'd120, 1'b1, 1'b1, 1'b0, 1'b1}   // R4 long run
   };

   function automatic logic gen_bit(input int kind, input int j);
      case (kind)
         0:       return (j % 5) == 4;
         1:       return (j % 3) == 2;
         2:       return (j % 2) == 1;
         4:       return (j % 4) == 3;
         default: return 1'b0;
      endcase
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      bit_en = 1'b0;
      irq_ack = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      pos = 0;
   endtask

   // two edges pass: one takes the bit, one lets the request settle
   task automatic send_bit(input logic b);
      @(negedge clk);
      rx_bit = b;
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic send_code(input int kind, input int n);
      for (int i = 0; i < n; i++) begin
         send_bit(gen_bit(kind, pos));
         pos++;
      end
   endtask

   task automatic pulse_ack();
      @(negedge clk);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      // R9 reset state
      do_reset();
      check("R9 act", act_det, 1'b0);
      check("R9 rel", rel_det, 1'b0);
      check("R9 irq", irq, 1'b0);

      for (int v = 0; v < 10; v++) begin
         do_reset();
         irq_mask = VECS[v].mask;
         send_code(int'(VECS[v].kind), int'(VECS[v].nbits));
         check("R1/R2/R10 act", act_det, VECS[v].e_act);
         check("R1/R2/R10 rel", rel_det, VECS[v].e_rel);
         check("R6/R7 irq", irq, VECS[v].e_irq);
      end

      // R5: a changing rx_bit with the enable low leaves everything alone
      do_reset();
      irq_mask = 1'b1;
      send_code(0, 25);
      check("R1 act", act_det, 1'b1);
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         rx_bit = k[0];
      end
      check("R5 act", act_det, 1'b1);
      send_code(0, 3);
      check("R5 act after resume", act_det, 1'b1);

      // R3: breaking the code clears the status but not the request
      send_bit(~gen_bit(0, pos));
      pos++;
      check("R3 act", act_det, 1'b0);
      check("R8 sticky", irq, 1'b1);
      pulse_ack();
      check("R8 ack", irq, 1'b0);
      send_code(0, 40);
      check("R3 redetect", act_det, 1'b1);
      check("R6 re-raise", irq, 1'b1);

      // R7: unmasking later, during the same detection, raises nothing
      do_reset();
      irq_mask = 1'b0;
      send_code(1, 25);
      check("R2 rel", rel_det, 1'b1);
      irq_mask = 1'b1;
      send_code(1, 6);
      check("R7 late unmask", irq, 1'b0);

      // R9: a reset in the middle of a detection clears it
      do_reset();
      irq_mask = 1'b1;
      send_code(0, 30);
      check("R6 irq", irq, 1'b1);
      do_reset();
      check("R9 act mid", act_det, 1'b0);
      check("R9 irq mid", irq, 1'b0);
      send_code(0, 24);
      check("R9 count restarted", act_det, 1'b0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule